// File: doc/BRIEF.md
# Repetition-Interval Pulse Window Gate

This block sits behind a pulse detector in a hyperbolic radio-navigation receiver. Each detection arrives as a record with a time stamp and a carrier phase value. The receiver expects a repeating frame of four pulses. Each pulse has its own programmable offset from the frame start, and the frame length is a programmable repetition interval. For each record the gate works out whether it is too early, inside the tolerance window, or late for the slot it is waiting on.

Records inside the window are passed downstream, tagged with their slot index, and the gate moves on to the next slot. Early records are dropped. A late record marks its slot as missed and is then tried against the following slot. If the shared time base runs past a slot's window while no record is waiting, the slot is marked missed and the gate moves on.

A new interval can be offered at any time. It applies from the next frame boundary onward. Every time comparison is modular, so the time counter may wrap freely.

Top module: `gri_pulse_gate`

## Requirements
- R1: Slot i expects its pulse at frame_base + offset[i], where offset[i] is bits [i*TW +: TW] of `slot_offsets`. The first frame starts at time 0. Each later frame starts one active interval after the previous one. The interval after reset is PERIOD_INIT.
- R2: After reset, `missed` is all ones, `out_valid` is 0, `rec_ready` is 1, and the gate waits on slot 0.
- R3: A record is early when its time is not after (expected - margin). An early record produces no output, leaves `missed` unchanged, and leaves the awaited slot unchanged.
- R4: A record is in window when its time is after (expected - margin) and not after (expected + margin). On the next clock, `out_valid` is 1 with `out_slot`, `out_phase` and `out_time` taken from that record. The slot's `missed` bit clears, and the gate moves to the next slot.
- R5: A record after (expected + margin) sets the slot's `missed` bit and moves the gate to the next slot. The record is held, with `rec_ready` low, and is judged again on the next clock against the new slot.
- R6: If no record is present and `cur_time` is after (expected + margin), the slot's `missed` bit is set and the gate moves to the next slot, one slot per clock.
- R7: "a after b" means that the signed TW-bit value of (a - b) is greater than zero. Windows that straddle the wrap of the time counter therefore classify correctly.
- R8: A pulse on `period_load` stages `period_value`. The staged value becomes the active interval only when slot NS-1 resolves, and it sets the length of the frame that follows. If several values are offered before a boundary, the last one wins.
- R9: Once slot NS-1 resolves, the gate waits on slot 0 of the next frame. Two successive accepted records carry successive slot indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_valid | input | 1 | Detection record present |
| rec_ready | output | 1 | Gate can take a new record (low while one is held) |
| rec_time | input | TW | Record time stamp |
| rec_phase | input | PW | Record carrier phase |
| cur_time | input | TW | Shared time base, used for timeouts |
| margin | input | TW | Half-width of every tolerance window |
| slot_offsets | input | NS*TW | Per-slot offsets from the frame start |
| period_load | input | 1 | Offer a new repetition interval |
| period_value | input | TW | Offered interval |
| out_valid | output | 1 | Accepted record on the outputs |
| out_slot | output | $clog2(NS) | Slot index of the accepted record |
| out_phase | output | PW | Phase of the accepted record |
| out_time | output | TW | Time stamp of the accepted record |
| missed | output | NS | One missed flag per slot |

## Verification
A wrong slot pointer or frame base does not show up right away. It appears one clock after the next record is judged, either as an `out_slot` value out of sequence or as a record dropped as early when it should have been passed. A wrong interval stays hidden until the frame after the boundary, when the first accept of the new frame fails to appear. A corrupted `missed` bit is visible on the ports one clock after the decision that touched it. A stuck hold register shows at once as `rec_ready` staying low.

// File: rtl/gri_gate_pkg.sv
// Shared types for the repetition-interval pulse window gate.
package gri_gate_pkg;
    typedef enum logic [1:0] {
        V_EARLY = 2'd0,
        V_HIT   = 2'd1,
        V_LATE  = 2'd2
    } verdict_e;
endpackage

// File: rtl/gri_window_classify.sv
// Classifies a time value against expected +/- margin.
// Assumes: all quantities are TW-bit modular; "after" means signed difference > 0.
module gri_window_classify #(
    parameter int TW = 16
) (
    input  logic [TW-1:0]          t,
    input  logic [TW-1:0]          expected,
    input  logic [TW-1:0]          margin,
    output gri_gate_pkg::verdict_e verdict
);
    logic [TW-1:0] lo_edge, hi_edge, d_lo, d_hi;
    logic          after_lo, after_hi;

    assign lo_edge  = expected - margin;
    assign hi_edge  = expected + margin;
    assign d_lo     = t - lo_edge;
    assign d_hi     = t - hi_edge;
    assign after_lo = !d_lo[TW-1] && (d_lo != '0);
    assign after_hi = !d_hi[TW-1] && (d_hi != '0);

    // Pick the verdict from the two wrap-safe comparisons.
    always_comb begin
        if (!after_lo)      verdict = gri_gate_pkg::V_EARLY;
        else if (!after_hi) verdict = gri_gate_pkg::V_HIT;
        else                verdict = gri_gate_pkg::V_LATE;
    end
endmodule

// File: rtl/gri_frame_seq.sv
// Tracks the awaited slot, the frame start and the active/staged interval.
// Assumes: advance is asserted once per resolved slot; the staged interval
// is applied when the last slot resolves.
module gri_frame_seq #(
    parameter int TW          = 16,
    parameter int NS          = 4,
    parameter int PERIOD_INIT = 1000,
    localparam int SW         = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             period_load,
    input  logic [TW-1:0]    period_value,
    input  logic [NS*TW-1:0] slot_offsets,
    output logic [SW-1:0]    slot,
    output logic [TW-1:0]    expected
);
    logic [TW-1:0] offs [NS];
    logic [TW-1:0] frame_base, act_period, pend_period;
    logic          pend_valid;
    logic          boundary;

    generate
        for (genvar i = 0; i < NS; i++) begin : g_unpack
            assign offs[i] = slot_offsets[i*TW +: TW];
        end
    endgenerate

    assign expected = frame_base + offs[slot];
    assign boundary = advance && (slot == SW'(NS-1));

    // Slot pointer, frame start and interval staging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot        <= '0;
            frame_base  <= '0;
            act_period  <= TW'(PERIOD_INIT);
            pend_period <= '0;
            pend_valid  <= 1'b0;
        end else begin
            if (boundary) begin
                slot       <= '0;
                frame_base <= frame_base + act_period;
                if (pend_valid) act_period <= pend_period;
                pend_valid <= 1'b0;
            end else if (advance) begin
                slot <= slot + 1'b1;
            end
            if (period_load) begin
                pend_period <= period_value;
                pend_valid  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/gri_pulse_gate.sv
// Window gate for time-stamped pulse records against a repeating frame.
// Assumes: one decision per clock; a late record is held and judged again
// against the next slot; timeouts are only taken when no record is waiting.
module gri_pulse_gate #(
    parameter int TW          = 16,
    parameter int PW          = 8,
    parameter int NS          = 4,
    parameter int PERIOD_INIT = 1000,
    localparam int SW         = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_valid,
    output logic             rec_ready,
    input  logic [TW-1:0]    rec_time,
    input  logic [PW-1:0]    rec_phase,
    input  logic [TW-1:0]    cur_time,
    input  logic [TW-1:0]    margin,
    input  logic [NS*TW-1:0] slot_offsets,
    input  logic             period_load,
    input  logic [TW-1:0]    period_value,
    output logic             out_valid,
    output logic [SW-1:0]    out_slot,
    output logic [PW-1:0]    out_phase,
    output logic [TW-1:0]    out_time,
    output logic [NS-1:0]    missed
);
    import gri_gate_pkg::*;

    logic          held_v;
    logic [TW-1:0] held_t;
    logic [PW-1:0] held_ph;
    logic          cand_v;
    logic [TW-1:0] cand_t;
    logic [PW-1:0] cand_ph;
    logic [SW-1:0] slot;
    logic [TW-1:0] expected;
    verdict_e      v_rec, v_now;
    logic          hit, late, tmo, advance;

    assign rec_ready = !held_v;
    assign cand_v    = held_v || rec_valid;
    assign cand_t    = held_v ? held_t  : rec_time;
    assign cand_ph   = held_v ? held_ph : rec_phase;

    gri_frame_seq #(.TW(TW), .NS(NS), .PERIOD_INIT(PERIOD_INIT)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .advance      (advance),
        .period_load  (period_load),
        .period_value (period_value),
        .slot_offsets (slot_offsets),
        .slot         (slot),
        .expected     (expected)
    );

    gri_window_classify #(.TW(TW)) u_rec_cls (
        .t(cand_t), .expected(expected), .margin(margin), .verdict(v_rec)
    );

    gri_window_classify #(.TW(TW)) u_now_cls (
        .t(cur_time), .expected(expected), .margin(margin), .verdict(v_now)
    );

    assign hit     = cand_v && (v_rec == V_HIT);
    assign late    = cand_v && (v_rec == V_LATE);
    assign tmo     = !cand_v && (v_now == V_LATE);
    assign advance = hit || late || tmo;

    // Hold a late record for re-evaluation; release it on any other verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v  <= 1'b0;
            held_t  <= '0;
            held_ph <= '0;
        end else if (late) begin
            held_v  <= 1'b1;
            held_t  <= cand_t;
            held_ph <= cand_ph;
        end else if (cand_v) begin
            held_v  <= 1'b0;
        end
    end

    // Per-slot missed flags: cleared on accept, set on late or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)             missed <= '1;
        else if (hit)           missed[slot] <= 1'b0;
        else if (late || tmo)   missed[slot] <= 1'b1;
    end

    // Registered output record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_slot  <= '0;
            out_phase <= '0;
            out_time  <= '0;
        end else begin
            out_valid <= hit;
            if (hit) begin
                out_slot  <= slot;
                out_phase <= cand_ph;
                out_time  <= cand_t;
            end
        end
    end
endmodule

// File: rtl/gri_pulse_gate_chk.sv
// Port-level properties of the pulse window gate, bound to the top module.
module gri_pulse_gate_chk #(
    parameter int NS  = 4,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rec_ready,
    input logic          out_valid,
    input logic [SW-1:0] out_slot,
    input logic [NS-1:0] missed
);
    logic rst_seen;

    // Remember that reset was active at the previous edge.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    p_reset_missed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |-> (missed == '1 && !out_valid && rec_ready));

    p_hit_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !missed[out_slot]);

    p_hold_no_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rec_ready) |-> !out_valid);

    p_one_flag_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(missed ^ $past(missed)) <= 1);

    p_slot_sequence_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |->
        (out_slot == (($past(out_slot) == SW'(NS-1)) ? '0 : $past(out_slot) + 1'b1)));
endmodule

bind gri_pulse_gate gri_pulse_gate_chk #(.NS(NS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_ready (rec_ready),
    .out_valid (out_valid),
    .out_slot  (out_slot),
    .missed    (missed)
);

// File: tb/gri_pulse_gate_bench.sv
module gri_pulse_gate_bench;
    localparam int TW = 16;
    localparam int PW = 8;
    localparam int NS = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rec_valid = 1'b0;
    logic             rec_ready;
    logic [TW-1:0]    rec_time = '0;
    logic [PW-1:0]    rec_phase = '0;
    logic [TW-1:0]    cur_time = '0;
    logic [TW-1:0]    margin = 16'd10;
    logic [NS*TW-1:0] slot_offsets = {16'd700, 16'd500, 16'd300, 16'd100};
    logic             period_load = 1'b0;
    logic [TW-1:0]    period_value = '0;
    logic             out_valid;
    logic [1:0]       out_slot;
    logic [PW-1:0]    out_phase;
    logic [TW-1:0]    out_time;
    logic [NS-1:0]    missed;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gri_pulse_gate #(.TW(TW), .PW(PW), .NS(NS), .PERIOD_INIT(1000)) u_gri_pulse_gate (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_time(rec_time), .rec_phase(rec_phase), .cur_time(cur_time),
        .margin(margin), .slot_offsets(slot_offsets), .period_load(period_load),
        .period_value(period_value), .out_valid(out_valid), .out_slot(out_slot),
        .out_phase(out_phase), .out_time(out_time), .missed(missed)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one record for one clock; return at the following falling edge.
    task automatic send(input logic [TW-1:0] t, input logic [PW-1:0] ph);
        rec_valid = 1'b1; rec_time = t; rec_phase = ph;
        @(posedge clk); @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic offer(input logic [TW-1:0] p);
        period_load = 1'b1; period_value = p;
        @(posedge clk); @(negedge clk);
        period_load = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [1:0] s,
                              input logic [TW-1:0] t, input logic [PW-1:0] ph);
        chk({req, " out_valid"}, 32'(out_valid), 32'd1);
        chk({req, " out_slot"},  32'(out_slot),  32'(s));
        chk({req, " out_time"},  32'(out_time),  32'(t));
        chk({req, " out_phase"}, 32'(out_phase), 32'(ph));
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        chk("R2 missed", 32'(missed), 32'hF);
        chk("R2 out_valid", 32'(out_valid), 32'd0);
        chk("R2 rec_ready", 32'(rec_ready), 32'd1);
    endtask

    task automatic t_early;
        send(16'd50, 8'h01);
        chk("R3 early out_valid", 32'(out_valid), 32'd0);
        chk("R3 early missed", 32'(missed), 32'hF);
        send(16'd90, 8'h02);   // exactly expected-margin: still early
        chk("R3 edge out_valid", 32'(out_valid), 32'd0);
        chk("R3 edge missed", 32'(missed), 32'hF);
    endtask

    task automatic t_hit_edge;
        send(16'd110, 8'h11);  // exactly expected+margin: in window, slot 0 still awaited (R3)
        expect_hit("R4 slot0", 2'd0, 16'd110, 8'h11);
        chk("R4 missed", 32'(missed), 32'hE);
    endtask

    task automatic t_late_reeval;
        send(16'd505, 8'h22);  // late for slot1, in window for slot2
        chk("R5 rec_ready held", 32'(rec_ready), 32'd0);
        chk("R5 no output yet", 32'(out_valid), 32'd0);
        @(posedge clk); @(negedge clk);
        expect_hit("R5 reeval", 2'd2, 16'd505, 8'h22);
        chk("R5 missed", 32'(missed), 32'hA);
        chk("R5 rec_ready back", 32'(rec_ready), 32'd1);
    endtask

    task automatic t_timeout;
        cur_time = 16'd711;
        @(posedge clk); @(negedge clk);
        chk("R6 timeout missed", 32'(missed), 32'hA);
        chk("R6 timeout no output", 32'(out_valid), 32'd0);
        send(16'd1100, 8'h33);  // slot0 of frame starting at 1000
        expect_hit("R9 R1 wrap to slot0", 2'd0, 16'd1100, 8'h33);
    endtask

    task automatic t_period_reload;
        offer(16'd5000);
        offer(16'd2000);
        send(16'd1300, 8'h41);
        expect_hit("R1 slot1", 2'd1, 16'd1300, 8'h41);
        send(16'd1500, 8'h42);
        send(16'd1700, 8'h43);
        expect_hit("R1 slot3", 2'd3, 16'd1700, 8'h43);
        chk("R4 all cleared", 32'(missed), 32'h0);
        send(16'd2100, 8'h44);  // boundary used old interval 1000
        expect_hit("R8 old interval", 2'd0, 16'd2100, 8'h44);
        cur_time = 16'd2711;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6 three timeouts", 32'(missed), 32'hE);
        send(16'd4100, 8'h45);  // frame at 2000+2000: last offer won
        expect_hit("R8 last offer", 2'd0, 16'd4100, 8'h45);
    endtask

    task automatic t_wrap;
        offer(16'd59436);       // frame after next begins at 65436
        cur_time = 16'd6711;
        repeat (7) @(posedge clk);
        @(negedge clk);
        cur_time = 16'd65000;
        chk("R6 frame timeouts", 32'(missed), 32'hF);
        chk("R6 no output", 32'(out_valid), 32'd0);
        send(16'd65520, 8'h51); // window is 65526..10 across wrap
        chk("R7 early across wrap", 32'(out_valid), 32'd0);
        chk("R7 early missed", 32'(missed), 32'hF);
        send(16'd5, 8'h52);
        expect_hit("R7 hit across wrap", 2'd0, 16'd5, 8'h52);
        chk("R7 missed", 32'(missed), 32'hE);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        t_reset();
        t_early();
        t_hit_edge();
        t_late_reeval();
        t_timeout();
        t_period_reload();
        t_wrap();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end
endmodule